// File: doc/BRIEF.md
# Priority Interrupt Presentation Controller

This block is the per-processor presentation stage of a two-layer interrupt controller. It keeps one 32-bit request word: the processor's current priority sits in bits 31:24 and the pending source number in bits 23:0. Beside it are an 8-bit pending priority and an 8-bit priority register for the inter-processor interrupt (IPI). Priorities run the other way from their numbers: a lower value is more favoured, and 0xFF means idle or masked.

A source layer offers interrupts as a source number and a priority on a valid/ready stream. The unit either takes an offer or hands it back as rejected. When it takes an offer it displaces any worse interrupt that was pending, and that one is rejected too. The processor drives a command port with four operations: set current priority, set IPI priority, accept, and end of interrupt. Every command completes in one clock. The effect of a command or offer presented in one cycle shows on all outputs after the next rising edge.

The unit drives a level interrupt line to the processor. Toward the source layer it sends one-cycle reject, end-of-interrupt and resend pulses, each with a 24-bit source number where one applies. A poll port shows the request word and the IPI priority at all times and has no side effects.

The offer stream is back-pressured by commands. `offer_ready` is low in any cycle where `cmd_valid` is high. An offer completes only in a cycle with `offer_valid && offer_ready`. The source layer must hold its offer steady until then. The command port has no ready signal: it is always accepted.

Top module: `ipc_present`

## Requirements
- R1: After reset the request word reads 0, the IPI priority reads 0xFF, the interrupt line is low, and there is no reject, end-of-interrupt, resend or response pulse.
- R2: `poll_word` is {current priority[7:0], pending source[23:0]}, and `poll_ipi` is the IPI priority. A pending source of 0 means nothing is pending, and the interrupt line is high exactly when the pending source is nonzero.
- R3: An offer with priority P is rejected, with a reject pulse carrying the offered source, when P >= current priority, or when something is pending at a pending priority <= P. In that case the request word is unchanged.
- R4: Any other offer raises a reject pulse for the previously pending source, if there was one. It then loads the offered source and P as pending and raises the interrupt line.
- R5: Accept (cmd_op 2) returns the whole request word from before the operation on `rsp_data` with a one-cycle `rsp_valid`. It sets current priority to the old pending priority, clears the pending source, sets pending priority to 0xFF and lowers the interrupt line.
- R6: Set current priority (cmd_op 0, value in cmd_data[7:0]) stores the value. If the value is lower than the old current priority and a source is pending with pending priority >= the value, that source is cancelled: the source field is cleared, pending priority becomes 0xFF, the line drops, and the source is rejected.
- R7: Set current priority with a value >= the old one, while nothing is pending, performs a resend. A resend issues a resend pulse. If the IPI priority is lower than the new current priority, it also presents the IPI as in R8.
- R8: Set IPI priority (cmd_op 1, value in cmd_data[7:0]) stores the value. If the value is below the current priority and nothing is pending at a priority <= the value, the IPI wins. Any pending source is then rejected, source 2 is loaded with the IPI priority as pending priority, and the line rises.
- R9: End of interrupt (cmd_op 3) sets current priority to cmd_data[31:24] and issues an end-of-interrupt pulse carrying cmd_data[23:0]. If nothing is pending, it also performs a resend as in R7.
- R10: `offer_ready` is low whenever `cmd_valid` is high. An offer presented then has no effect. An offer completed with source 0 is dropped with no effect and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A processor command is present this cycle |
| cmd_op | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 end of interrupt |
| cmd_data | input | 32 | Command operand |
| offer_valid | input | 1 | Source layer offers an interrupt |
| offer_ready | output | 1 | Offer is taken this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Level interrupt to the processor |
| rsp_valid | output | 1 | Accept response pulse |
| rsp_data | output | 32 | Request word returned by accept |
| poll_word | output | 32 | Live request word |
| poll_ipi | output | 8 | Live IPI priority |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Source number ended |
| resend_valid | output | 1 | Resend request pulse to the source layer |

## Verification
The hardest situations to reach are the ones where two rules interact in a single operation. One is an IPI priority write that displaces a pending device source. Another is an end of interrupt that lowers the priority bar, finds nothing pending, and so presents the IPI through the resend path. A third is a cancel whose new priority exactly equals the pending priority. Each needs a specific history of current priority, pending state and IPI priority built up first. The bench gets there by long deterministic pseudo-random sequences that mix all four commands with offers, drawing priorities and sources from small sets. Collisions and ties therefore recur many times. Every output is compared after every operation against an arithmetic model of the requirements.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } ipc_op_e;
endpackage

// File: rtl/ipc_decide.sv
module ipc_decide
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic              cmd_go,
  input  ipc_op_e           cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  input  logic              offer_go,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] cur_cppr,
  input  logic [SRC_W-1:0]  cur_xsrc,
  input  logic [PRIO_W-1:0] cur_pend,
  input  logic [PRIO_W-1:0] cur_ipi,
  output logic [PRIO_W-1:0] nxt_cppr,
  output logic [SRC_W-1:0]  nxt_xsrc,
  output logic [PRIO_W-1:0] nxt_pend,
  output logic [PRIO_W-1:0] nxt_ipi,
  output logic              raise,
  output logic              lower,
  output logic              rej_go,
  output logic [SRC_W-1:0]  rej_num,
  output logic              eoi_go,
  output logic [SRC_W-1:0]  eoi_num,
  output logic              resend_go,
  output logic              rsp_go
);
  localparam logic [PRIO_W-1:0] IDLE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  logic busy;
  logic ipi_chk;
  logic do_resend;
  logic [PRIO_W-1:0] arg_prio;

  assign busy = (cur_xsrc != '0);
  assign arg_prio = cmd_data[PRIO_W-1:0];

  always_comb begin
    nxt_cppr  = cur_cppr;
    nxt_xsrc  = cur_xsrc;
    nxt_pend  = cur_pend;
    nxt_ipi   = cur_ipi;
    raise     = 1'b0;
    lower     = 1'b0;
    rej_go    = 1'b0;
    rej_num   = '0;
    eoi_go    = 1'b0;
    eoi_num   = '0;
    resend_go = 1'b0;
    rsp_go    = 1'b0;
    ipi_chk   = 1'b0;
    do_resend = 1'b0;

    if (cmd_go) begin
      unique case (cmd_op)
        OP_SET_CPPR: begin
          nxt_cppr = arg_prio;
          if (arg_prio < cur_cppr) begin
            if (busy && (arg_prio <= cur_pend)) begin
              rej_go   = 1'b1;
              rej_num  = cur_xsrc;
              nxt_xsrc = '0;
              nxt_pend = IDLE;
              lower    = 1'b1;
            end
          end else if (!busy) begin
            do_resend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          nxt_ipi = arg_prio;
          if (arg_prio < cur_cppr) ipi_chk = 1'b1;
        end
        OP_ACCEPT: begin
          rsp_go   = 1'b1;
          nxt_cppr = cur_pend;
          nxt_xsrc = '0;
          nxt_pend = IDLE;
          lower    = 1'b1;
        end
        default: begin
          nxt_cppr = cmd_data[PRIO_W+SRC_W-1:SRC_W];
          eoi_go   = 1'b1;
          eoi_num  = cmd_data[SRC_W-1:0];
          if (!busy) do_resend = 1'b1;
        end
      endcase
    end else if (offer_go && (offer_src != '0)) begin
      if ((offer_prio >= cur_cppr) || (busy && (cur_pend <= offer_prio))) begin
        rej_go  = 1'b1;
        rej_num = offer_src;
      end else begin
        if (busy) begin
          rej_go  = 1'b1;
          rej_num = cur_xsrc;
        end
        nxt_xsrc = offer_src;
        nxt_pend = offer_prio;
        raise    = 1'b1;
      end
    end

    if (do_resend) begin
      resend_go = 1'b1;
      if (cur_ipi < nxt_cppr) ipi_chk = 1'b1;
    end

    if (ipi_chk && !(busy && (cur_pend <= nxt_ipi))) begin
      if (busy) begin
        rej_go  = 1'b1;
        rej_num = cur_xsrc;
      end
      nxt_xsrc = IPI_NUM;
      nxt_pend = nxt_ipi;
      raise    = 1'b1;
    end
  end
endmodule

// File: rtl/ipc_state.sv
module ipc_state #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIO_W-1:0] nxt_cppr,
  input  logic [SRC_W-1:0]  nxt_xsrc,
  input  logic [PRIO_W-1:0] nxt_pend,
  input  logic [PRIO_W-1:0] nxt_ipi,
  input  logic              raise,
  input  logic              lower,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [SRC_W-1:0]  xsrc_q,
  output logic [PRIO_W-1:0] pend_q,
  output logic [PRIO_W-1:0] ipi_q,
  output logic              irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      xsrc_q <= '0;
      pend_q <= '1;
      ipi_q  <= '1;
      irq_q  <= 1'b0;
    end else begin
      cppr_q <= nxt_cppr;
      xsrc_q <= nxt_xsrc;
      pend_q <= nxt_pend;
      ipi_q  <= nxt_ipi;
      if (raise)      irq_q <= 1'b1;
      else if (lower) irq_q <= 1'b0;
    end
  end

  AST_IRQ_TRACKS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xsrc_q != '0)); // R2
  AST_IDLE_PRIO_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (xsrc_q == '0) |-> (pend_q == '1)); // R5
endmodule

// File: rtl/ipc_srcport.sv
module ipc_srcport #(
  parameter int SRC_W  = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rej_go,
  input  logic [SRC_W-1:0]  rej_num,
  input  logic              eoi_go,
  input  logic [SRC_W-1:0]  eoi_num,
  input  logic              resend_go,
  input  logic              rsp_go,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_valid,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_valid <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rej_valid    <= rej_go;
      rej_src      <= rej_go ? rej_num : '0;
      eoi_valid    <= eoi_go;
      eoi_src      <= eoi_go ? eoi_num : '0;
      resend_valid <= resend_go;
      rsp_valid    <= rsp_go;
      if (rsp_go) rsp_data <= rsp_word;
    end
  end

  AST_REJECT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0)); // R3
endmodule

// File: rtl/ipc_present.sv
module ipc_present
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  input  logic                    offer_valid,
  output logic                    offer_ready,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  output logic                    irq_out,
  output logic                    rsp_valid,
  output logic [PRIO_W+SRC_W-1:0] rsp_data,
  output logic [PRIO_W+SRC_W-1:0] poll_word,
  output logic [PRIO_W-1:0]       poll_ipi,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_valid
);
  localparam int WORD_W = PRIO_W + SRC_W;

  ipc_op_e op;
  logic [PRIO_W-1:0] cppr_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  xsrc_q;
  logic [PRIO_W-1:0] nxt_cppr, nxt_pend, nxt_ipi;
  logic [SRC_W-1:0]  nxt_xsrc;
  logic raise, lower, rej_go, eoi_go, resend_go, rsp_go;
  logic [SRC_W-1:0] rej_num, eoi_num;

  assign op          = ipc_op_e'(cmd_op);
  assign offer_ready = !cmd_valid;
  assign poll_word   = {cppr_q, xsrc_q};
  assign poll_ipi    = ipi_q;

  ipc_decide #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_decide (
    .cmd_go(cmd_valid), .cmd_op(op), .cmd_data(cmd_data),
    .offer_go(offer_valid && offer_ready), .offer_src(offer_src), .offer_prio(offer_prio),
    .cur_cppr(cppr_q), .cur_xsrc(xsrc_q), .cur_pend(pend_q), .cur_ipi(ipi_q),
    .nxt_cppr(nxt_cppr), .nxt_xsrc(nxt_xsrc), .nxt_pend(nxt_pend), .nxt_ipi(nxt_ipi),
    .raise(raise), .lower(lower), .rej_go(rej_go), .rej_num(rej_num),
    .eoi_go(eoi_go), .eoi_num(eoi_num), .resend_go(resend_go), .rsp_go(rsp_go)
  );

  ipc_state #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .nxt_cppr(nxt_cppr), .nxt_xsrc(nxt_xsrc), .nxt_pend(nxt_pend), .nxt_ipi(nxt_ipi),
    .raise(raise), .lower(lower),
    .cppr_q(cppr_q), .xsrc_q(xsrc_q), .pend_q(pend_q), .ipi_q(ipi_q), .irq_q(irq_out)
  );

  ipc_srcport #(.SRC_W(SRC_W), .WORD_W(WORD_W)) u_srcport (
    .clk(clk), .rst_n(rst_n),
    .rej_go(rej_go), .rej_num(rej_num), .eoi_go(eoi_go), .eoi_num(eoi_num),
    .resend_go(resend_go), .rsp_go(rsp_go), .rsp_word(poll_word),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_valid(resend_valid), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_OFFER_STALLED_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !offer_ready); // R10
  AST_ACCEPT_LOWERS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_ACCEPT) |=> (!irq_out && rsp_valid)); // R5
  AST_CPPR_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_SET_CPPR) |=> (poll_word[WORD_W-1:SRC_W] == $past(cmd_data[PRIO_W-1:0]))); // R6
  AST_EOI_CARRIES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_EOI) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0]))); // R9
endmodule

// File: tb/ipc_present_tb.sv
module ipc_present_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic offer_valid = 1'b0;
  logic offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0] offer_prio = '0;
  logic irq_out, rsp_valid, rej_valid, eoi_valid, resend_valid;
  logic [31:0] rsp_data, poll_word;
  logic [7:0] poll_ipi;
  logic [23:0] rej_src, eoi_src;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]  m_cppr, m_pend, m_ipi;
  logic [23:0] m_src;
  logic e_rej, e_eoi, e_res, e_rsp;
  logic [23:0] e_rej_src, e_eoi_src;
  logic [31:0] e_rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_present u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .offer_valid(offer_valid), .offer_ready(offer_ready), .offer_src(offer_src),
    .offer_prio(offer_prio), .irq_out(irq_out), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .poll_word(poll_word), .poll_ipi(poll_ipi), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clr_exp();
    e_rej = 0; e_eoi = 0; e_res = 0; e_rsp = 0;
    e_rej_src = '0; e_eoi_src = '0; e_rsp_data = '0;
  endtask

  // IPI presentation rule (R8), applied to the model
  task automatic m_ipi_check();
    if (!((m_src != 0) && (m_pend <= m_ipi))) begin
      if (m_src != 0) begin e_rej = 1; e_rej_src = m_src; end
      m_src = 24'd2;
      m_pend = m_ipi;
    end
  endtask

  // Resend rule (R7)
  task automatic m_resend();
    e_res = 1;
    if (m_ipi < m_cppr) m_ipi_check();
  endtask

  task automatic compare(input string tag);
    chk(tag, "poll_word", poll_word, {m_cppr, m_src});
    chk(tag, "poll_ipi", {24'd0, poll_ipi}, {24'd0, m_ipi});
    chk(tag, "irq_out", {31'd0, irq_out}, {31'd0, (m_src != 0)});
    chk(tag, "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
    if (e_rej) chk(tag, "rej_src", {8'd0, rej_src}, {8'd0, e_rej_src});
    chk(tag, "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
    if (e_eoi) chk(tag, "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
    chk(tag, "resend_valid", {31'd0, resend_valid}, {31'd0, e_res});
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp});
    if (e_rsp) chk(tag, "rsp_data", rsp_data, e_rsp_data);
  endtask

  task automatic finish_op(input string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare(tag);
    @(negedge clk);
    cmd_valid = 0;
    offer_valid = 0;
  endtask

  // Command; optionally a competing offer that must stall (R10)
  task automatic do_cmd(input logic [1:0] op, input logic [31:0] data, input bit with_offer, input string tag);
    logic [7:0] v;
    cmd_valid = 1; cmd_op = op; cmd_data = data;
    if (with_offer) begin
      offer_valid = 1; offer_src = 24'd7; offer_prio = 8'h00;
    end
    #1;
    chk("R10", "offer_ready", {31'd0, offer_ready}, 32'd0);
    clr_exp();
    v = data[7:0];
    case (op)
      2'd0: begin
        if (v < m_cppr) begin
          m_cppr = v;
          if ((m_src != 0) && (v <= m_pend)) begin
            e_rej = 1; e_rej_src = m_src; m_src = 0; m_pend = 8'hFF;
          end
        end else begin
          m_cppr = v;
          if (m_src == 0) m_resend();
        end
      end
      2'd1: begin
        m_ipi = v;
        if (v < m_cppr) m_ipi_check();
      end
      2'd2: begin
        e_rsp = 1; e_rsp_data = {m_cppr, m_src};
        m_cppr = m_pend; m_src = 0; m_pend = 8'hFF;
      end
      default: begin
        m_cppr = data[31:24];
        e_eoi = 1; e_eoi_src = data[23:0];
        if (m_src == 0) m_resend();
      end
    endcase
    finish_op(tag);
  endtask

  task automatic do_offer(input logic [23:0] s, input logic [7:0] p, input string tag);
    offer_valid = 1; offer_src = s; offer_prio = p;
    clr_exp();
    if (s != 0) begin
      if ((p >= m_cppr) || ((m_src != 0) && (m_pend <= p))) begin
        e_rej = 1; e_rej_src = s;
      end else begin
        if (m_src != 0) begin e_rej = 1; e_rej_src = m_src; end
        m_src = s; m_pend = p;
      end
    end
    finish_op(tag);
  endtask

  task automatic model_reset();
    m_cppr = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF;
    clr_exp();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    logic [7:0] plist [8];
    plist[0] = 8'h00; plist[1] = 8'h10; plist[2] = 8'h40; plist[3] = 8'h41;
    plist[4] = 8'h80; plist[5] = 8'hC0; plist[6] = 8'hFE; plist[7] = 8'hFF;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    compare("R1");

    // R7: raise bar with nothing pending -> resend pulse, IPI idle so no load
    do_cmd(2'd0, 32'h80, 0, "R7");
    // R3: offer not below current priority is rejected
    do_offer(24'h000005, 8'h80, "R3");
    // R4: better offer loads and raises the line
    do_offer(24'h000005, 8'h40, "R4");
    // R3: equal-priority offer with something pending is rejected
    do_offer(24'h000009, 8'h40, "R3");
    // R4: a more favoured offer displaces and rejects the old one
    do_offer(24'h00ABCD, 8'h10, "R4");
    // R10: an offer of source 0 has no effect
    do_offer(24'h000000, 8'h00, "R10");
    // R8: IPI at a worse priority than the pending one loses
    do_cmd(2'd1, 32'h20, 0, "R8");
    // R8: IPI at a better priority displaces the pending source
    do_cmd(2'd1, 32'h08, 1, "R8");
    // R5: accept returns the word and drops the line
    do_cmd(2'd2, 32'h0, 0, "R5");
    // R9: EOI restores priority, nothing pending -> resend and IPI re-presents
    do_cmd(2'd3, 32'hFF00_0002, 0, "R9");
    // R6: cancel when new priority equals pending priority
    do_cmd(2'd0, 32'h08, 0, "R6");
    do_cmd(2'd1, 32'hFF, 0, "R8");
    do_cmd(2'd0, 32'hFF, 0, "R7");
    do_offer(24'h000033, 8'h50, "R4");
    // R6: more favoured value but still worse than pending keeps it
    do_cmd(2'd0, 32'h60, 0, "R6");
    do_cmd(2'd0, 32'h20, 1, "R6");

    // R2/R3..R9: long pseudo-random mix over small value sets
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] sel;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = lfsr[2:0];
      case (sel)
        3'd0: do_cmd(2'd0, {24'd0, plist[lfsr[5:3]]}, lfsr[6], "R6");
        3'd1: do_cmd(2'd1, {24'd0, plist[lfsr[5:3]]}, lfsr[6], "R8");
        3'd2: do_cmd(2'd2, 32'd0, lfsr[6], "R5");
        3'd3: do_cmd(2'd3, {plist[lfsr[5:3]], 21'd0, lfsr[9:7]}, lfsr[6], "R9");
        default: do_offer({21'd0, lfsr[9:7]}, plist[lfsr[5:3]], "R2");
      endcase
    end

    // R1: reset in the middle returns to the idle state
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    compare("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule